// File: doc/BRIEF.md
# Port-Based VLAN Egress Filter

The block turns a forwarding request into a final egress decision for a nine-port switch whose highest-numbered port (index 8) is the management port. A request names the ingress port, a candidate destination vector from address lookup and a traffic class. The block combines that vector with a per-ingress egress mask, per-port receive and transmit blocking, class-specific receive enables on the management port and a global forwarding switch. One cycle later it presents the allowed destination vector and a drop indication.

Configuration is held in a small byte-addressed register space that is written only. Two pages are used. The control page holds one control byte per port and a switch-mode byte. The mask page holds one 16-bit egress mask per ingress port, stored as two bytes. Isolating every user port so that it reaches only the management port takes one mask write per port.

Top module: `pvlan_egress_filter`

## Requirements
- R1: After reset every egress mask is 0x1FF, every port control byte is 0 and forwarding is off. Until it is enabled, every request is reported with `dec_drop`=1 and `dec_egress`=0.
- R2: A request with `req_valid`=1 produces `dec_valid`=1 exactly one clock later. `dec_valid` is 0 in any cycle that does not follow a valid request.
- R3: The switch-mode byte is at control page (`cfg_page`=0x00), offset 0x0B. Bit 1 of that byte enables forwarding. While that bit is clear, every decision drops with an all-zero vector.
- R4: The egress mask of ingress port i is in page 0x31. Its low byte is at offset 2*i and its high byte at 2*i+1. Only mask bits 8:0 take part in the decision, and the output never includes a port whose mask bit is clear.
- R5: The ingress port's own bit is always cleared from `dec_egress`, even when both the candidate and the mask include it.
- R6: The control byte of port p is at control page offset p (0..8). Bit 1 (transmit block) removes port p from every egress vector.
- R7: Bit 0 (receive block) of the ingress port's control byte causes every frame from that port to be dropped with an all-zero vector.
- R8: For frames entering port 8, control bits 2, 3 and 4 of port 8 enable broadcast, multicast and unicast reception. A frame whose class bit is clear is dropped. On other ingress ports these bits have no effect. Class codes are unicast=0, multicast=1 and broadcast=2.
- R9: A frame whose resulting egress vector is zero is dropped. Whenever `dec_drop`=1, `dec_egress` is 0.
- R10: With every user port's mask set to itself plus port 8, traffic from user ports reaches port 8 only, and port 8 can reach all user ports.
- R11: Writes to addresses outside the mapped registers, and requests with an ingress port number above 8, change no state. Such requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register byte write strobe |
| cfg_page | input | 8 | Register page select |
| cfg_off | input | 8 | Byte offset inside the page |
| cfg_wdata | input | 8 | Write data byte |
| req_valid | input | 1 | Request qualifier |
| req_port | input | 4 | Ingress port number |
| req_cand | input | 9 | Candidate destination vector |
| req_class | input | 2 | Frame class: 0 unicast, 1 multicast, 2 broadcast |
| dec_valid | output | 1 | Decision valid, one cycle after request |
| dec_egress | output | 9 | Allowed egress vector |
| dec_drop | output | 1 | Frame is dropped |

## Verification
A corrupted mask or control byte shows up as a wrong `dec_egress` bit or a wrong drop on the very next decision from the affected ingress port or toward the affected egress port. The bench therefore writes one register and then issues a request in the following cycle, so that a lost or misaddressed byte surfaces one clock after that request. Wrong decoding of a page or offset, such as a high and low mask byte swapped or control bytes of two ports aliased, is caught by probing each port and each mask half separately.

// File: rtl/pvlan_pkg.sv
package pvlan_pkg;
  localparam int unsigned NPORTS    = 9;
  localparam int unsigned PORT_W    = 4;
  localparam int unsigned MASK_W    = 16;
  localparam int unsigned MGMT_PORT = 8;
  localparam logic [7:0] PG_CTRL    = 8'h00;
  localparam logic [7:0] PG_MASK    = 8'h31;
  localparam logic [7:0] OFF_MODE   = 8'h0B;
  localparam int unsigned MODE_FWD_BIT = 1;
  localparam int unsigned CTL_RXBLK = 0;
  localparam int unsigned CTL_TXBLK = 1;
  localparam int unsigned CTL_BC    = 2;
  localparam int unsigned CTL_MC    = 3;
  localparam int unsigned CTL_UC    = 4;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_RSVD  = 2'd3
  } frame_class_e;
endpackage

// File: rtl/pvlan_cfg_regs.sv
module pvlan_cfg_regs
  import pvlan_pkg::*;
#(
  parameter int unsigned N  = NPORTS,
  parameter int unsigned MW = MASK_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic [7:0]          page,
  input  logic [7:0]          off,
  input  logic [7:0]          wdata,
  output logic [N-1:0][MW-1:0] masks,
  output logic [N-1:0][7:0]   ctls,
  output logic                fwd_en
);
  localparam int unsigned MB = MW / 8;

  logic [7:0] mode_q;

  for (genvar p = 0; p < N; p++) begin : g_port
    for (genvar b = 0; b < MB; b++) begin : g_byte
      logic hit;
      assign hit = we && page == PG_MASK && off == 8'(p * MB + b);
      always_ff @(posedge clk) begin
        if (rst) masks[p][b*8 +: 8] <= (b == 0) ? 8'hFF : ((b == 1) ? 8'h01 : 8'h00);
        else if (hit) masks[p][b*8 +: 8] <= wdata;
      end
    end
    logic chit;
    assign chit = we && page == PG_CTRL && off == 8'(p);
    always_ff @(posedge clk) begin
      if (rst) ctls[p] <= 8'h00;
      else if (chit) ctls[p] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 8'h00;
    else if (we && page == PG_CTRL && off == OFF_MODE) mode_q <= wdata;
  end
  assign fwd_en = mode_q[MODE_FWD_BIT];

  AST_RESET_MODE: assert property (@(posedge clk) $past(rst) |-> !fwd_en); // R1
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && page == PG_CTRL && off == OFF_MODE) |=> $stable(fwd_en)); // R11
endmodule

// File: rtl/pvlan_decide.sv
module pvlan_decide
  import pvlan_pkg::*;
#(
  parameter int unsigned N  = NPORTS,
  parameter int unsigned MW = MASK_W,
  parameter int unsigned PW = PORT_W,
  parameter int unsigned MG = MGMT_PORT
) (
  input  logic [N-1:0][MW-1:0] masks,
  input  logic [N-1:0][7:0]   ctls,
  input  logic                fwd_en,
  input  logic [PW-1:0]       port,
  input  logic [N-1:0]        cand,
  input  logic [1:0]          cls,
  output logic [N-1:0]        egress,
  output logic                drop
);
  logic [N-1:0] tx_ok;
  logic [N-1:0] self_bit;
  logic [N-1:0] row_mask;
  logic         port_ok, rx_blk, class_ok;
  logic [N-1:0] raw;

  for (genvar p = 0; p < N; p++) begin : g_tx
    assign tx_ok[p]    = ~ctls[p][CTL_TXBLK];
    assign self_bit[p] = (32'(port) == p);
  end

  assign port_ok = 32'(port) < N;

  always_comb begin
    row_mask = '0;
    rx_blk   = 1'b0;
    for (int p = 0; p < N; p++) begin
      if (self_bit[p]) begin
        row_mask = masks[p][N-1:0];
        rx_blk   = ctls[p][CTL_RXBLK];
      end
    end
  end

  always_comb begin
    class_ok = 1'b1;
    if (32'(port) == MG) begin
      case (frame_class_e'(cls))
        CLS_UNI:   class_ok = ctls[MG][CTL_UC];
        CLS_MULTI: class_ok = ctls[MG][CTL_MC];
        CLS_BCAST: class_ok = ctls[MG][CTL_BC];
        default:   class_ok = 1'b0;
      endcase
    end
  end

  assign raw = cand & row_mask & tx_ok & ~self_bit;

  always_comb begin
    drop = !fwd_en || !port_ok || rx_blk || !class_ok || raw == '0;
    egress = drop ? '0 : raw;
  end
endmodule

// File: rtl/pvlan_egress_filter.sv
module pvlan_egress_filter
  import pvlan_pkg::*;
#(
  parameter int unsigned N  = NPORTS,
  parameter int unsigned MW = MASK_W,
  parameter int unsigned PW = PORT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [7:0]   cfg_page,
  input  logic [7:0]   cfg_off,
  input  logic [7:0]   cfg_wdata,
  input  logic         req_valid,
  input  logic [PW-1:0] req_port,
  input  logic [N-1:0] req_cand,
  input  logic [1:0]   req_class,
  output logic         dec_valid,
  output logic [N-1:0] dec_egress,
  output logic         dec_drop
);
  logic [N-1:0][MW-1:0] masks;
  logic [N-1:0][7:0]    ctls;
  logic                 fwd_en;
  logic [N-1:0]         egr_c;
  logic                 drop_c;

  pvlan_cfg_regs #(.N(N), .MW(MW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .page(cfg_page), .off(cfg_off),
    .wdata(cfg_wdata), .masks(masks), .ctls(ctls), .fwd_en(fwd_en)
  );

  pvlan_decide #(.N(N), .MW(MW), .PW(PW)) u_dec (
    .masks(masks), .ctls(ctls), .fwd_en(fwd_en), .port(req_port),
    .cand(req_cand), .cls(req_class), .egress(egr_c), .drop(drop_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_egress <= '0;
      dec_drop   <= 1'b0;
    end else begin
      dec_valid <= req_valid;
      if (req_valid) begin
        dec_egress <= egr_c;
        dec_drop   <= drop_c;
      end
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec_valid); // R2
  AST_DROP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    dec_valid && dec_drop |-> dec_egress == '0); // R9
  AST_NO_SELF: assert property (@(posedge clk) disable iff (rst)
    req_valid && 32'(req_port) < N |=> dec_egress[$past(req_port)] == 1'b0); // R5
  AST_FWD_OFF: assert property (@(posedge clk) disable iff (rst)
    req_valid && !fwd_en |=> dec_drop); // R3
  AST_SUBSET: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (dec_egress & ~$past(req_cand)) == '0); // R4
endmodule

// File: tb/sim_pvlan_egress_filter.sv
module sim_pvlan_egress_filter;
  logic clk = 0, rst = 1;
  logic cfg_we = 0;
  logic [7:0] cfg_page = 0, cfg_off = 0, cfg_wdata = 0;
  logic req_valid = 0;
  logic [3:0] req_port = 0;
  logic [8:0] req_cand = 0;
  logic [1:0] req_class = 0;
  logic dec_valid, dec_drop;
  logic [8:0] dec_egress;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pvlan_egress_filter u0 (.*);

  task automatic chk(string req, logic [8:0] eg, logic dr, logic vl);
    n_chk++;
    if (dec_egress !== eg || dec_drop !== dr || dec_valid !== vl) begin
      n_bad++;
      $display("FAIL %s: got eg=%h drop=%b v=%b exp eg=%h drop=%b v=%b",
               req, dec_egress, dec_drop, dec_valid, eg, dr, vl);
    end
  endtask

  task automatic wr(logic [7:0] pg, logic [7:0] of, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_page = pg; cfg_off = of; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic req(logic [3:0] p, logic [8:0] c, logic [1:0] k,
                     string tag, logic [8:0] eg, logic dr);
    @(negedge clk);
    req_valid = 1; req_port = p; req_cand = c; req_class = k;
    @(negedge clk);
    req_valid = 0;
    chk(tag, eg, dr, 1'b1);
  endtask

  task automatic mask(int p, logic [8:0] m);
    wr(8'h31, 8'(2*p), m[7:0]);
    wr(8'h31, 8'(2*p+1), {7'd0, m[8]});
  endtask

  task automatic t_reset;
    @(negedge clk); chk("R2 idle", 9'h000, 1'b0, 1'b0);
    req(4'd0, 9'h1FF, 2'd0, "R1 fwd off", 9'h000, 1'b1);
    @(negedge clk); chk("R2 no valid", 9'h000, 1'b1, 1'b0);
  endtask

  task automatic t_fwd;
    wr(8'h00, 8'h0B, 8'h02);
    req(4'd0, 9'h1FF, 2'd0, "R1 default mask", 9'h1FE, 1'b0);
    wr(8'h00, 8'h0B, 8'hFD);
    req(4'd0, 9'h1FF, 2'd0, "R3 bit1 clear", 9'h000, 1'b1);
    wr(8'h00, 8'h0B, 8'h02);
  endtask

  task automatic t_mask;
    mask(2, 9'h00F);
    req(4'd2, 9'h1FF, 2'd0, "R4 mask low", 9'h00B, 1'b0);
    mask(2, 9'h100);
    req(4'd2, 9'h1FF, 2'd0, "R4 mask high byte", 9'h100, 1'b0);
    wr(8'h31, 8'h05, 8'hFE);
    req(4'd2, 9'h1FF, 2'd0, "R4 bits above 8 ignored", 9'h000, 1'b1);
    mask(2, 9'h1FF);
    req(4'd3, 9'h008, 2'd0, "R5 self only", 9'h000, 1'b1);
    req(4'd3, 9'h018, 2'd0, "R5 self cleared", 9'h010, 1'b0);
  endtask

  task automatic t_ctl;
    wr(8'h00, 8'h05, 8'h02);
    req(4'd0, 9'h1FF, 2'd0, "R6 tx block", 9'h1DE, 1'b0);
    wr(8'h00, 8'h05, 8'h00);
    wr(8'h00, 8'h04, 8'h01);
    req(4'd4, 9'h1FF, 2'd0, "R7 rx block", 9'h000, 1'b1);
    req(4'd0, 9'h010, 2'd0, "R7 other port unaffected", 9'h010, 1'b0);
    wr(8'h00, 8'h04, 8'h00);
  endtask

  task automatic t_class;
    req(4'd8, 9'h0FF, 2'd2, "R8 bcast off", 9'h000, 1'b1);
    wr(8'h00, 8'h08, 8'h04);
    req(4'd8, 9'h0FF, 2'd2, "R8 bcast on", 9'h0FF, 1'b0);
    req(4'd8, 9'h0FF, 2'd1, "R8 mcast off", 9'h000, 1'b1);
    req(4'd8, 9'h0FF, 2'd0, "R8 ucast off", 9'h000, 1'b1);
    wr(8'h00, 8'h08, 8'h18);
    req(4'd8, 9'h001, 2'd1, "R8 mcast on", 9'h001, 1'b0);
    req(4'd8, 9'h001, 2'd0, "R8 ucast on", 9'h001, 1'b0);
    wr(8'h00, 8'h08, 8'h00);
    req(4'd1, 9'h100, 2'd2, "R8 user port ignores class", 9'h100, 1'b0);
    wr(8'h00, 8'h08, 8'h1C);
  endtask

  task automatic t_isolate;
    for (int p = 0; p < 8; p++) mask(p, 9'h100 | (9'd1 << p));
    req(4'd1, 9'h1FF, 2'd0, "R10 user to cpu only", 9'h100, 1'b0);
    req(4'd1, 9'h0FC, 2'd0, "R9 R10 user to user dropped", 9'h000, 1'b1);
    req(4'd8, 9'h1FF, 2'd0, "R10 cpu reaches all", 9'h0FF, 1'b0);
  endtask

  task automatic t_oob;
    wr(8'h00, 8'h0C, 8'hFF);
    wr(8'h32, 8'h00, 8'h00);
    wr(8'h31, 8'h12, 8'h00);
    req(4'd8, 9'h0FF, 2'd0, "R11 unmapped writes", 9'h0FF, 1'b0);
    req(4'd9, 9'h1FF, 2'd0, "R11 bad port", 9'h000, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset; t_fwd; t_mask; t_ctl; t_class; t_isolate; t_oob;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule